// File: doc/BRIEF.md
# I2C FIFO Chunk Sequencer

This block is the buffered front end of an I2C master. Software fills a 32-byte transmit FIFO (or sizes a receive chunk), programs a chunk length, and then writes a target address and direction. The block then drives a byte-level I2C engine through a request/acknowledge command interface. The commands are start-with-address, write byte, read byte and stop.

A transfer moves one chunk at a time. At the end of each chunk the block raises a chunk-done status bit. If the end flag for the current direction was armed, it then issues a stop. Otherwise it stalls with the bus held until software sets a continue bit, which launches the next chunk of the programmed length. A NACK on the address phase, or on a written data byte, aborts the transfer with a stop and sets a status bit of its own. The interrupt output is the OR of the status bits, each masked by its enable bit. Registers are reached through a simple byte-wide bus.

Top module: `i2c_chunk_seq`

## Requirements
- R1: After reset the block is idle: busy (CTL0 bit 6) reads 0, status reads 0, `irq` is 0, `eng_req` is 0 and the TX count (offset 0xA) reads 0.
- R2: A write to offset 0x6 pushes into the TX FIFO; a push into a full FIFO (32 entries) is dropped. A read of offset 0x7 with `reg_re` pops the RX FIFO in arrival order. Writing 1 to bit 0 of offset 0x5 empties the TX FIFO, and writing 1 to bit 1 empties the RX FIFO. Counts read at 0xA (TX) and 0xB (RX).
- R3: When FIFO mode (offset 0x1 bit 6) is set and the block is idle, a write to offset 0x4 (bit 7 = read, bits 6:0 = address) starts a transfer. The first command is START (`eng_cmd`=0), with `eng_wdata` = {address, read bit}. With FIFO mode clear, the write is ignored.
- R4: A chunk moves (length register + 1) bytes. The TX length is at offset 0x8 and the RX length at 0x9. Write bytes go out as WRITE (`eng_cmd`=1) in TX FIFO order.
- R5: At chunk end, status bit 3 is set. The block then issues no request until CTL0 bit 3 (continue) is written. The continue bit reads back 0 once it has launched the next chunk.
- R6: If the end flag for the direction (CTL0 bit 1 for transmit, bit 0 for receive) is set when a chunk completes, the block issues STOP (`eng_cmd`=3) and goes idle. The flag then reads 0.
- R7: Reads use READ (`eng_cmd`=2). `eng_nack_out` is 1 only for the last byte of the final chunk. Received bytes enter the RX FIFO.
- R8: A NACK on the START command sets status bit 0, issues STOP and ends the transfer with no data commands.
- R9: A NACK on a written data byte sets status bit 4, issues STOP and clears busy.
- R10: Status bits (offset 0x2) clear when 1 is written to them. `irq` is the OR of the status bits ANDed with the mask at offset 0x3.
- R11: Writing CTL0 bit 7 (master reset) returns the block to idle. It clears status, FIFO mode, flags and both FIFOs.
- R12: Once `eng_req` is raised, it stays high with a stable `eng_cmd` until `eng_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops RX data) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Masked interrupt |
| eng_req | output | 1 | Command request to byte engine |
| eng_cmd | output | 2 | 0 start, 1 write, 2 read, 3 stop |
| eng_wdata | output | 8 | Address byte or data byte |
| eng_nack_out | output | 1 | NACK the byte being read |
| eng_ack | input | 1 | Engine command done (one-cycle pulse) |
| eng_nack | input | 1 | Target NACKed, valid with eng_ack |
| eng_rdata | input | 8 | Received byte, valid with eng_ack |

## Verification
The assertions take three things for granted about the engine side. `eng_ack` is a single-cycle pulse that arrives only while `eng_req` is high. `eng_nack` is meaningful only alongside that pulse. A master reset is not issued in the same cycle as an engine acknowledge. The bench's engine model answers each request exactly once, one cycle after it sees the request, and drops the pulse the cycle after. It attaches a NACK only at a chosen command index. Software writes in the bench are spaced by full clock cycles, so no register write coincides with reset.

// File: rtl/i2c_chunk_seq.sv
module i2c_chunk_seq #(
  parameter int DEPTH = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  output logic          eng_req,
  output logic [1:0]    eng_cmd,
  output logic [7:0]    eng_wdata,
  output logic          eng_nack_out,
  input  logic          eng_ack,
  input  logic          eng_nack,
  input  logic [7:0]    eng_rdata
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [1:0] C_START = 2'd0, C_WR = 2'd1, C_RD = 2'd2, C_STOP = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_XFER, S_HOLD, S_STOP} st_t;
  st_t st;

  logic          dir_rd, tx_end, rx_end, cpu_rdy, fifo_mode;
  logic [6:0]    addr7;
  logic [PW-1:0] rem, txlen, rxlen;
  logic [7:0]    sts, mask;
  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire wr_at   = reg_we;
  wire mrst    = wr_at && reg_addr == AW'(0) && reg_wdata[7];
  wire acked   = eng_req && eng_ack;
  wire done_b  = acked && st == S_XFER;
  wire end_f   = dir_rd ? rx_end : tx_end;
  wire busy    = st != S_IDLE;
  wire tx_push = wr_at && reg_addr == AW'(6) && tx_cnt != CW'(DEPTH);
  wire tx_pop  = done_b && !dir_rd && tx_cnt != '0;
  wire rx_push = done_b && dir_rd && rx_cnt != CW'(DEPTH);
  wire rx_pop  = reg_re && reg_addr == AW'(7) && rx_cnt != '0;
  wire fr_tx   = wr_at && reg_addr == AW'(5) && reg_wdata[0];
  wire fr_rx   = wr_at && reg_addr == AW'(5) && reg_wdata[1];

  assign eng_req      = st == S_START || st == S_XFER || st == S_STOP;
  assign eng_cmd      = st == S_START ? C_START : st == S_STOP ? C_STOP : (dir_rd ? C_RD : C_WR);
  assign eng_wdata    = st == S_START ? {addr7, dir_rd} : tx_mem[tx_rp];
  assign eng_nack_out = st == S_XFER && dir_rd && rem == '0 && rx_end;
  assign irq          = |(sts & mask);

  always_comb begin
    case (reg_addr)
      AW'(0):  reg_rdata = {1'b0, busy, 2'b0, cpu_rdy, 1'b0, tx_end, rx_end};
      AW'(1):  reg_rdata = {1'b0, fifo_mode, 6'b0};
      AW'(2):  reg_rdata = sts;
      AW'(3):  reg_rdata = mask;
      AW'(7):  reg_rdata = rx_mem[rx_rp];
      AW'(8):  reg_rdata = 8'(txlen);
      AW'(9):  reg_rdata = 8'(rxlen);
      AW'(10): reg_rdata = 8'(tx_cnt);
      AW'(11): reg_rdata = 8'(rx_cnt);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= reg_wdata;
    if (rx_push) rx_mem[rx_wp] <= eng_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mrst || fr_tx) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
    if (!rst_n || mrst || fr_rx) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mrst) begin
      st <= S_IDLE; dir_rd <= 1'b0; addr7 <= '0; rem <= '0;
      tx_end <= 1'b0; rx_end <= 1'b0; cpu_rdy <= 1'b0; fifo_mode <= 1'b0;
      sts <= '0; mask <= '0; txlen <= '0; rxlen <= '0;
    end else begin
      if (wr_at) begin
        case (reg_addr)
          AW'(0): begin
            tx_end <= reg_wdata[1];
            rx_end <= reg_wdata[0];
            if (reg_wdata[3]) cpu_rdy <= 1'b1;
          end
          AW'(1): fifo_mode <= reg_wdata[6];
          AW'(2): sts <= sts & ~reg_wdata;
          AW'(3): mask <= reg_wdata;
          AW'(8): txlen <= reg_wdata[PW-1:0];
          AW'(9): rxlen <= reg_wdata[PW-1:0];
          default: ;
        endcase
      end
      case (st)
        S_IDLE:
          if (wr_at && reg_addr == AW'(4) && fifo_mode) begin
            dir_rd  <= reg_wdata[7];
            addr7   <= reg_wdata[6:0];
            cpu_rdy <= 1'b0;
            st      <= S_START;
          end
        S_START:
          if (acked) begin
            if (eng_nack) begin
              sts[0] <= 1'b1;
              st     <= S_STOP;
            end else begin
              rem <= dir_rd ? rxlen : txlen;
              st  <= S_XFER;
            end
          end
        S_XFER:
          if (acked) begin
            if (!dir_rd && eng_nack) begin
              sts[4] <= 1'b1;
              st     <= S_STOP;
            end else if (rem == '0) begin
              sts[3] <= 1'b1;
              if (end_f) begin
                if (dir_rd) rx_end <= 1'b0;
                else        tx_end <= 1'b0;
                st <= S_STOP;
              end else begin
                st <= S_HOLD;
              end
            end else begin
              rem <= rem - 1'b1;
            end
          end
        S_HOLD:
          if (cpu_rdy) begin
            cpu_rdy <= 1'b0;
            rem     <= dir_rd ? rxlen : txlen;
            st      <= S_XFER;
          end
        S_STOP:
          if (acked) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || mrst)
    eng_req && !eng_ack |=> eng_req && $stable(eng_cmd));
  // R5
  chunk_done_chk: assert property (@(posedge clk) disable iff (!rst_n || mrst)
    done_b && rem == '0 && !(eng_nack && !dir_rd) |=> sts[3]);
  // R6
  end_stop_chk: assert property (@(posedge clk) disable iff (!rst_n || mrst)
    done_b && rem == '0 && end_f && !(eng_nack && !dir_rd) |=> st == S_STOP && !end_f);
  // R8
  addr_nack_chk: assert property (@(posedge clk) disable iff (!rst_n || mrst)
    acked && st == S_START && eng_nack |=> st == S_STOP && sts[0]);
  // R9
  data_nack_chk: assert property (@(posedge clk) disable iff (!rst_n || mrst)
    done_b && !dir_rd && eng_nack |=> st == S_STOP && sts[4]);
  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past((acked && eng_cmd == C_STOP) || mrst));
  // R5
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || mrst)
    st == S_HOLD && !cpu_rdy |=> !eng_req || st == S_XFER);
endmodule

// File: tb/tb_i2c_chunk_seq.sv
module tb_i2c_chunk_seq;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0, reg_re = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq, eng_req, eng_nack_out;
  logic [1:0] eng_cmd;
  logic [7:0] eng_wdata;
  logic eng_ack = 0, eng_nack = 0;
  logic [7:0] eng_rdata = 0;

  i2c_chunk_seq dut (.*);

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0, ln = 0, nack_idx = -1;
  logic [1:0] lcmd [128];
  logic [7:0] lwd  [128];
  logic       lnk  [128];

  always @(negedge clk) begin
    if (eng_ack) begin
      eng_ack = 0; eng_nack = 0;
    end else if (eng_req) begin
      if (ln < 128) begin
        lcmd[ln] = eng_cmd; lwd[ln] = eng_wdata; lnk[ln] = eng_nack_out;
      end
      eng_rdata = 8'h5C ^ ln[7:0];
      eng_nack = (ln == nack_idx);
      eng_ack = 1;
      ln++;
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    if (a == 4'd7) reg_re = 1;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic wait_bit(input logic [3:0] a, input int b, input logic val, input string r);
    logic [7:0] v;
    int n = 0;
    do begin rd(a, v); n++; end while (v[b] !== val && n < 3000);
    chk(r, int'(v[b]), int'(val));
  endtask

  logic [7:0] v;
  int ok;

  initial begin
    #(8 * 190000);
    nfail++; nchk++;
    $display("FAIL R12 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, v); chk("R1 ctl0", v, 0);
    rd(2, v); chk("R1 status", v, 0);
    rd(10, v); chk("R1 txcnt", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 req", eng_req, 0);

    // R3 ignored without fifo mode
    ln = 0; wr(4, 8'h2A); repeat (6) @(negedge clk);
    chk("R3 no start when mode off", ln, 0);
    rd(0, v); chk("R3 idle when mode off", v[6], 0);
    wr(1, 8'h40);

    // R2 overflow and fifo reset
    wr(5, 3);
    for (int i = 0; i < 33; i++) wr(6, i[7:0]);
    rd(10, v); chk("R2 tx full count", v, 32);
    wr(5, 1); rd(10, v); chk("R2 tx reset", v, 0);

    // R3 R4 R6 write sweep
    for (int L = 1; L <= 32; L++) begin
      wr(5, 3);
      for (int i = 0; i < L; i++) wr(6, 8'((L * 7 + i) & 255));
      wr(8, 8'(L - 1)); wr(0, 8'h02); wr(2, 8'hFF);
      ln = 0; wr(4, 8'h2A);
      wait_bit(0, 6, 0, "R6 write idle");
      chk("R4 write count", ln, L + 2);
      chk("R3 start cmd", lcmd[0], 0);
      chk("R3 start byte", lwd[0], 8'h54);
      ok = 1;
      for (int i = 0; i < L; i++)
        if (lcmd[i + 1] !== 2'd1 || lwd[i + 1] !== 8'((L * 7 + i) & 255)) ok = 0;
      chk("R4 write bytes", ok, 1);
      chk("R6 stop cmd", lcmd[L + 1], 3);
      rd(2, v); chk("R5 chunk status", v[3], 1);
      rd(0, v); chk("R6 tx_end cleared", v[1], 0);
    end

    // R7 read sweep
    for (int L = 1; L <= 32; L++) begin
      wr(5, 2); wr(9, 8'(L - 1)); wr(0, 8'h01); wr(2, 8'hFF);
      ln = 0; wr(4, 8'hB3);
      wait_bit(0, 6, 0, "R7 read idle");
      chk("R7 read count", ln, L + 2);
      chk("R3 read start byte", lwd[0], 8'h67);
      ok = 1;
      for (int i = 1; i <= L; i++)
        if (lcmd[i] !== 2'd2 || lnk[i] !== (i == L)) ok = 0;
      chk("R7 read cmds and nack", ok, 1);
      rd(11, v); chk("R2 rx count", v, L);
      ok = 1;
      for (int i = 0; i < L; i++) begin
        rd(7, v);
        if (v !== (8'h5C ^ 8'(i + 1))) ok = 0;
      end
      chk("R2 rx order", ok, 1);
    end

    // R2 rx fifo reset
    wr(9, 2); wr(0, 1); ln = 0; wr(4, 8'hB3);
    wait_bit(0, 6, 0, "R7 idle");
    wr(5, 2); rd(11, v); chk("R2 rx reset", v, 0);

    // R5 R6 multi-chunk write
    wr(5, 3);
    for (int i = 0; i < 12; i++) wr(6, 8'(8'h90 + i));
    wr(8, 3); wr(0, 0); wr(2, 8'hFF);
    ln = 0; wr(4, 8'h2A);
    wait_bit(2, 3, 1, "R5 first chunk");
    repeat (10) @(negedge clk);
    chk("R5 held after chunk", ln, 5);
    rd(0, v); chk("R5 busy while held", v[6], 1);
    wr(2, 8); wr(0, 8'h08);
    wait_bit(2, 3, 1, "R5 second chunk");
    chk("R5 second chunk count", ln, 9);
    rd(0, v); chk("R5 continue self-clears", v[3], 0);
    wr(2, 8); wr(0, 8'h0A);
    wait_bit(0, 6, 0, "R6 multi idle");
    chk("R6 multi count", ln, 14);
    chk("R6 multi stop", lcmd[13], 3);
    ok = 1;
    for (int i = 0; i < 12; i++) if (lwd[i + 1 + (i / 4) * 0] !== 8'(8'h90 + i)) ok = 0;
    chk("R4 multi bytes", ok, 1);
    rd(0, v); chk("R6 flags clear", v & 8'h0B, 0);

    // R8 address nack and R10 irq
    wr(2, 8'hFF); wr(5, 1); wr(6, 1); wr(8, 0); wr(0, 2);
    nack_idx = 0; ln = 0; wr(4, 8'h2A);
    wait_bit(0, 6, 0, "R8 idle");
    chk("R8 only start and stop", ln, 2);
    chk("R8 stop", lcmd[1], 3);
    rd(2, v); chk("R8 addr nack status", v, 8'h01);
    chk("R10 irq masked off", irq, 0);
    wr(3, 8'h01); @(negedge clk); chk("R10 irq masked on", irq, 1);
    wr(2, 8'h01); rd(2, v); chk("R10 w1c", v, 0);
    chk("R10 irq after clear", irq, 0);
    wr(3, 0);

    // R9 data nack
    wr(5, 1);
    for (int i = 0; i < 6; i++) wr(6, 8'(i));
    wr(8, 5); wr(0, 2);
    nack_idx = 2; ln = 0; wr(4, 8'h2A);
    wait_bit(0, 6, 0, "R9 busy clear");
    chk("R9 count", ln, 4);
    chk("R9 stop", lcmd[3], 3);
    rd(2, v); chk("R9 data nack status", v[4], 1);
    nack_idx = -1;

    // R11 master reset while held
    wr(2, 8'hFF); wr(5, 1);
    for (int i = 0; i < 8; i++) wr(6, 8'(i));
    wr(8, 1); wr(0, 0); ln = 0; wr(4, 8'h2A);
    wait_bit(2, 3, 1, "R11 held");
    wr(0, 8'h80);
    rd(0, v); chk("R11 idle", v, 0);
    rd(2, v); chk("R11 status", v, 0);
    rd(1, v); chk("R11 mode cleared", v, 0);
    rd(10, v); chk("R11 tx fifo cleared", v, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule